// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This block sits beside one processor and decides which interrupt, if any, is currently presented to it. Source units offer interrupts, each with a source number and a one-byte priority. The block compares each offer against the processor's current priority and against whatever it already holds. It then takes the offer or turns it down. When it takes an offer, it may hand a less favored held interrupt back to its source. Priorities follow the rule that a smaller byte is more favored, and 0xFF stands for "nothing".

The processor drives four commands into the block: accept the presented interrupt, signal end of interrupt, write a new current priority, and write the inter-processor interrupt priority. Toward the source units, the block raises three single-cycle pulses: a reject that returns a held interrupt, an end-of-interrupt notice carrying a source number, and a resend request that asks all sources to offer again what they still have. A command and an offer may arrive in the same cycle. In that case the command is applied first and the offer is judged against the state the command leaves behind. Every response appears in the cycle after its inputs are sampled.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset, the pending word `pend_word` is zero, `ipi_prio` is 0xFF, the internal pending priority is 0xFF, `irq_out` is low, and no pulse output is active.
- R2: An offer whose priority is greater than or equal to the current processor priority (`pend_word` bits 31:24) is answered with `offer_refuse` one cycle later, and the state is left unchanged.
- R3: An offer is refused when an interrupt is already held (`pend_word` bits 23:0 nonzero) and the held pending priority is less than or equal to the offered priority.
- R4: Any other offer is answered with `offer_take`. Its source number goes into bits 23:0 and its priority becomes the pending priority, and `irq_out` rises. A held interrupt owned by a source is first returned by a `rej_valid` pulse that carries its number.
- R5: Command ACCEPT (`cmd_op`=0) returns the old pending word on `rsp_word` with `rsp_valid`. It moves the pending priority into bits 31:24, clears bits 23:0, resets the pending priority to 0xFF and lowers `irq_out`.
- R6: Command SET_CPPR (`cmd_op`=2, new value in `cmd_data` bits 7:0) with a value below the old current priority, while an interrupt is held with a pending priority at or above the new value, drops the held interrupt. It clears bits 23:0, lowers `irq_out` and rejects the held interrupt to its owner.
- R7: SET_CPPR with a value not below the old one, while nothing is held, pulses `resend_req`. Before that pulse, it presents the inter-processor interrupt if that interrupt's priority is below the new current priority. A more favored write with nothing held issues no resend.
- R8: Command SET_IPI (`cmd_op`=3, value in bits 7:0) updates `ipi_prio`. If the value is below the current priority, it presents source number 2 at that priority and raises `irq_out`. This is skipped when a held interrupt's pending priority is at or below the value. A held source-owned interrupt is rejected when the inter-processor interrupt is presented.
- R9: Command EOI (`cmd_op`=1) loads `cmd_data` bits 31:24 as the current priority and pulses `eoi_valid` with bits 23:0. It pulses `resend_req`, with the R7 inter-processor re-check, only if nothing is held.
- R10: A held inter-processor interrupt that is displaced by an offer or a command produces no `rej_valid` pulse.
- R11: When a command and an offer share a cycle, the offer is judged against the state left by the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | An interrupt offer is present |
| offer_src | input | SRC_W | Source number of the offer |
| offer_prio | input | 8 | Priority of the offer |
| offer_take | output | 1 | Offer of the previous cycle was taken |
| offer_refuse | output | 1 | Offer of the previous cycle was refused |
| cmd_valid | input | 1 | A processor command is present |
| cmd_op | input | 2 | 0 accept, 1 EOI, 2 set current priority, 3 set inter-processor priority |
| cmd_data | input | 8+SRC_W | Command operand |
| rsp_valid | output | 1 | `rsp_word` holds an accept result |
| rsp_word | output | 8+SRC_W | Pending word returned by accept |
| irq_out | output | 1 | Interrupt line to the processor |
| pend_word | output | 8+SRC_W | Current priority and pending source number |
| ipi_prio | output | 8 | Inter-processor interrupt priority |
| rej_valid | output | 1 | Reject pulse toward the sources |
| rej_src | output | SRC_W | Source number being rejected |
| eoi_valid | output | 1 | End-of-interrupt pulse toward the sources |
| eoi_src | output | SRC_W | Source number of the EOI |
| resend_req | output | 1 | Pulse asking all sources to resend |

## Verification
The main function is offer arbitration. The bench drives offers whose priority sits at, above and below the current priority. It also drives offers against an empty holder, a source-owned holder and an inter-processor holder. These cases separate the two refusal conditions from preemption with and without a returned reject. Command sequences walk each priority write through its favored and unfavored branches, with and without a held interrupt, which separates drop, resend and silent update. Same-cycle command-plus-offer patterns show whether the offer is judged before or after the command.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_EOI      = 2'd1,
    OP_SET_CPPR = 2'd2,
    OP_SET_IPI  = 2'd3
  } irqp_op_e;
endpackage

// File: rtl/irqp_ipi_check.sv
module irqp_ipi_check import irqp_pkg::*; #(
  parameter int SRC_W = 24
) (
  input  logic              want,
  input  logic [SRC_W-1:0]  held_src,
  input  logic [PRIO_W-1:0] held_prio,
  input  logic [PRIO_W-1:0] ipi_level,
  input  logic              held_owned,
  output logic              present,
  output logic              bump
);
  logic busy;
  assign busy    = held_src != '0;
  // a held interrupt at least as favored as the IPI keeps its place
  assign present = want && !(busy && (held_prio <= ipi_level));
  assign bump    = present && busy && held_owned;
endmodule

// File: rtl/irqp_cmd_stage.sv
module irqp_cmd_stage import irqp_pkg::*; #(
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input  logic              cmd_valid,
  input  irqp_op_e          cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [PRIO_W-1:0] cur_cppr,
  input  logic [SRC_W-1:0]  cur_xisr,
  input  logic [PRIO_W-1:0] cur_pp,
  input  logic [PRIO_W-1:0] cur_mfrr,
  input  logic              cur_owned,
  output logic [PRIO_W-1:0] nxt_cppr,
  output logic [SRC_W-1:0]  nxt_xisr,
  output logic [PRIO_W-1:0] nxt_pp,
  output logic [PRIO_W-1:0] nxt_mfrr,
  output logic              nxt_owned,
  output logic              rej_fire,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_fire,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_fire,
  output logic              acc_fire,
  output logic [WORD_W-1:0] acc_word
);
  logic [PRIO_W-1:0] new_prio, eoi_prio;
  logic [PRIO_W-1:0] s1_cppr, s1_pp, s1_mfrr;
  logic [SRC_W-1:0]  s1_xisr;
  logic              s1_owned;
  logic              drop_fire, ipi_want, ipi_present, ipi_bump, has_pend;

  assign new_prio = cmd_data[PRIO_W-1:0];
  assign eoi_prio = cmd_data[WORD_W-1 -: PRIO_W];
  assign eoi_src  = cmd_data[SRC_W-1:0];
  assign acc_word = {cur_cppr, cur_xisr};
  assign has_pend = cur_xisr != '0;

  // first step: the command's own effect
  always_comb begin
    s1_cppr     = cur_cppr;
    s1_xisr     = cur_xisr;
    s1_pp       = cur_pp;
    s1_mfrr     = cur_mfrr;
    s1_owned    = cur_owned;
    drop_fire   = 1'b0;
    eoi_fire    = 1'b0;
    resend_fire = 1'b0;
    acc_fire    = 1'b0;
    ipi_want    = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_ACCEPT: begin
          acc_fire = 1'b1;
          s1_cppr  = cur_pp;
          s1_xisr  = '0;
          s1_pp    = PRIO_NONE;
          s1_owned = 1'b0;
        end
        OP_EOI: begin
          eoi_fire = 1'b1;
          s1_cppr  = eoi_prio;
          if (!has_pend) begin
            resend_fire = 1'b1;
            ipi_want    = cur_mfrr < eoi_prio;
          end
        end
        OP_SET_CPPR: begin
          s1_cppr = new_prio;
          if (new_prio < cur_cppr) begin
            if (has_pend && (new_prio <= cur_pp)) begin
              drop_fire = cur_owned;
              s1_xisr   = '0;
              s1_pp     = PRIO_NONE;
              s1_owned  = 1'b0;
            end
          end else if (!has_pend) begin
            resend_fire = 1'b1;
            ipi_want    = cur_mfrr < new_prio;
          end
        end
        OP_SET_IPI: begin
          s1_mfrr  = new_prio;
          ipi_want = new_prio < cur_cppr;
        end
        default: ;
      endcase
    end
  end

  irqp_ipi_check #(.SRC_W(SRC_W)) ipi_chk_i (
    .want       (ipi_want),
    .held_src   (s1_xisr),
    .held_prio  (s1_pp),
    .ipi_level  (s1_mfrr),
    .held_owned (s1_owned),
    .present    (ipi_present),
    .bump       (ipi_bump)
  );

  // second step: inter-processor presentation
  always_comb begin
    nxt_cppr  = s1_cppr;
    nxt_xisr  = s1_xisr;
    nxt_pp    = s1_pp;
    nxt_mfrr  = s1_mfrr;
    nxt_owned = s1_owned;
    rej_fire  = drop_fire;
    rej_src   = cur_xisr;
    if (ipi_present) begin
      if (ipi_bump) begin
        rej_fire = 1'b1;
        rej_src  = s1_xisr;
      end
      nxt_xisr  = SRC_W'(IPI_SRC);
      nxt_pp    = s1_mfrr;
      nxt_owned = 1'b0;
    end
  end
endmodule

// File: rtl/irqp_offer_stage.sv
module irqp_offer_stage import irqp_pkg::*; #(
  parameter int SRC_W = 24
) (
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic [PRIO_W-1:0] in_cppr,
  input  logic [SRC_W-1:0]  in_xisr,
  input  logic [PRIO_W-1:0] in_pp,
  input  logic              in_owned,
  output logic              take,
  output logic              refuse,
  output logic [SRC_W-1:0]  nxt_xisr,
  output logic [PRIO_W-1:0] nxt_pp,
  output logic              nxt_owned,
  output logic              bump_fire,
  output logic [SRC_W-1:0]  bump_src
);
  logic busy;
  assign busy      = in_xisr != '0;
  assign refuse    = offer_valid &&
                     ((offer_prio >= in_cppr) || (busy && (in_pp <= offer_prio)));
  assign take      = offer_valid && !refuse;
  assign bump_fire = take && busy && in_owned;
  assign bump_src  = in_xisr;
  assign nxt_xisr  = take ? offer_src  : in_xisr;
  assign nxt_pp    = take ? offer_prio : in_pp;
  assign nxt_owned = take ? 1'b1       : in_owned;
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter import irqp_pkg::*; #(
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     offer_valid,
  input  logic [SRC_W-1:0]         offer_src,
  input  logic [PRIO_W-1:0]        offer_prio,
  output logic                     offer_take,
  output logic                     offer_refuse,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
  output logic                     rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]  rsp_word,
  output logic                     irq_out,
  output logic [PRIO_W+SRC_W-1:0]  pend_word,
  output logic [PRIO_W-1:0]        ipi_prio,
  output logic                     rej_valid,
  output logic [SRC_W-1:0]         rej_src,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src,
  output logic                     resend_req
);
  localparam int WORD_W = PRIO_W + SRC_W;

  logic [PRIO_W-1:0] cppr_q, pp_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic              owned_q;

  logic [PRIO_W-1:0] c_cppr, c_pp, c_mfrr;
  logic [SRC_W-1:0]  c_xisr, c_rej_src, c_eoi_src;
  logic              c_owned, c_rej, c_eoi, c_resend, c_acc;
  logic [WORD_W-1:0] c_acc_word;

  logic [SRC_W-1:0]  o_xisr, o_bump_src;
  logic [PRIO_W-1:0] o_pp;
  logic              o_owned, o_take, o_refuse, o_bump;

  irqp_cmd_stage #(.SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) cmd_i (
    .cmd_valid   (cmd_valid),
    .cmd_op      (irqp_op_e'(cmd_op)),
    .cmd_data    (cmd_data),
    .cur_cppr    (cppr_q),
    .cur_xisr    (xisr_q),
    .cur_pp      (pp_q),
    .cur_mfrr    (mfrr_q),
    .cur_owned   (owned_q),
    .nxt_cppr    (c_cppr),
    .nxt_xisr    (c_xisr),
    .nxt_pp      (c_pp),
    .nxt_mfrr    (c_mfrr),
    .nxt_owned   (c_owned),
    .rej_fire    (c_rej),
    .rej_src     (c_rej_src),
    .eoi_fire    (c_eoi),
    .eoi_src     (c_eoi_src),
    .resend_fire (c_resend),
    .acc_fire    (c_acc),
    .acc_word    (c_acc_word)
  );

  // offer is judged after the command has been applied
  irqp_offer_stage #(.SRC_W(SRC_W)) offer_i (
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .in_cppr     (c_cppr),
    .in_xisr     (c_xisr),
    .in_pp       (c_pp),
    .in_owned    (c_owned),
    .take        (o_take),
    .refuse      (o_refuse),
    .nxt_xisr    (o_xisr),
    .nxt_pp      (o_pp),
    .nxt_owned   (o_owned),
    .bump_fire   (o_bump),
    .bump_src    (o_bump_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q       <= '0;
      xisr_q       <= '0;
      pp_q         <= PRIO_NONE;
      mfrr_q       <= PRIO_NONE;
      owned_q      <= 1'b0;
      irq_out      <= 1'b0;
      offer_take   <= 1'b0;
      offer_refuse <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_word     <= '0;
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_req   <= 1'b0;
    end else begin
      cppr_q       <= c_cppr;
      xisr_q       <= o_xisr;
      pp_q         <= o_pp;
      mfrr_q       <= c_mfrr;
      owned_q      <= o_owned;
      irq_out      <= o_xisr != '0;
      offer_take   <= o_take;
      offer_refuse <= o_refuse;
      rsp_valid    <= c_acc;
      rsp_word     <= c_acc ? c_acc_word : '0;
      rej_valid    <= c_rej || o_bump;
      rej_src      <= c_rej ? c_rej_src : (o_bump ? o_bump_src : '0);
      eoi_valid    <= c_eoi;
      eoi_src      <= c_eoi ? c_eoi_src : '0;
      resend_req   <= c_resend;
    end
  end

  assign pend_word = {cppr_q, xisr_q};
  assign ipi_prio  = mfrr_q;
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker import irqp_pkg::*; #(
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = PRIO_W + SRC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              offer_valid,
  input logic [PRIO_W-1:0] offer_prio,
  input logic              offer_take,
  input logic              offer_refuse,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [WORD_W-1:0] cmd_data,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_word,
  input logic              irq_out,
  input logic [WORD_W-1:0] pend_word,
  input logic [PRIO_W-1:0] ipi_prio,
  input logic              rej_valid,
  input logic [SRC_W-1:0]  rej_src,
  input logic              eoi_valid,
  input logic [SRC_W-1:0]  eoi_src
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pend_word == '0 && ipi_prio == PRIO_NONE && !irq_out && !rej_valid));

  p_refuse_cppr_r2: assert property (@(posedge clk) disable iff (rst)
    (offer_valid && !cmd_valid && offer_prio >= pend_word[WORD_W-1 -: PRIO_W])
    |=> (offer_refuse && !offer_take));

  p_take_raise_r4: assert property (@(posedge clk) disable iff (rst)
    offer_take |-> (irq_out && pend_word[SRC_W-1:0] != '0));

  p_resp_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(offer_take && offer_refuse));

  p_rej_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    rej_valid |-> (rej_src != '0 && rej_src != SRC_W'(IPI_SRC)));

  p_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && !offer_valid)
    |=> (rsp_valid && rsp_word == $past(pend_word) && !irq_out &&
         pend_word[SRC_W-1:0] == '0));

  p_ipi_present_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3 && !offer_valid && pend_word[SRC_W-1:0] == '0 &&
     cmd_data[PRIO_W-1:0] < pend_word[WORD_W-1 -: PRIO_W])
    |=> (irq_out && pend_word[SRC_W-1:0] == SRC_W'(IPI_SRC)));

  p_eoi_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1)
    |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0]) &&
         pend_word[WORD_W-1 -: PRIO_W] == $past(cmd_data[WORD_W-1 -: PRIO_W])));
endmodule

bind cpu_irq_presenter irqp_checker #(.SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .offer_valid  (offer_valid),
  .offer_prio   (offer_prio),
  .offer_take   (offer_take),
  .offer_refuse (offer_refuse),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_data     (cmd_data),
  .rsp_valid    (rsp_valid),
  .rsp_word     (rsp_word),
  .irq_out      (irq_out),
  .pend_word    (pend_word),
  .ipi_prio     (ipi_prio),
  .rej_valid    (rej_valid),
  .rej_src      (rej_src),
  .eoi_valid    (eoi_valid),
  .eoi_src      (eoi_src)
);

// File: tb/cpu_irq_presenter_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_presenter_tb_top;
  localparam logic [1:0] ACC = 2'd0, EOI = 2'd1, CPPR = 2'd2, IPI = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        offer_take, offer_refuse;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_word;
  logic        irq_out;
  logic [31:0] pend_word;
  logic [7:0]  ipi_prio;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        resend_req;

  always #4 clk = ~clk;

  cpu_irq_presenter #(.SRC_W(24), .IPI_SRC(2)) dut_i (
    .clk(clk), .rst(rst),
    .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
    .offer_take(offer_take), .offer_refuse(offer_refuse),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .irq_out(irq_out), .pend_word(pend_word), .ipi_prio(ipi_prio),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
  );

  typedef struct {
    logic [31:0] word;
    logic        irq;
    logic [7:0]  ipi;
    logic        take;
    logic        refuse;
    logic        rej_v;
    logic [23:0] rej_s;
    logic        eoi_v;
    logic [23:0] eoi_s;
    logic        res;
    logic        rsp_v;
    logic [31:0] rsp_w;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  function automatic exp_t ex(input logic [31:0] word, input logic irq,
                              input logic [7:0] ipi, input string tag);
    exp_t e;
    e.word = word; e.irq = irq; e.ipi = ipi;
    e.take = 1'b0; e.refuse = 1'b0; e.rej_v = 1'b0; e.rej_s = '0;
    e.eoi_v = 1'b0; e.eoi_s = '0; e.res = 1'b0; e.rsp_v = 1'b0; e.rsp_w = '0;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic cv, input logic [1:0] op, input logic [31:0] d,
                       input logic ov, input logic [23:0] os, input logic [7:0] opr,
                       input exp_t e);
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_data = d;
    offer_valid = ov; offer_src = os; offer_prio = opr;
    exp_q.push_back(e);
  endtask

  task automatic cmp(input logic [31:0] a, input logic [31:0] b, input string f,
                     input string tag, inout bit bad);
    if (a !== b) begin
      $display("FAIL %s %s: actual %h expected %h", tag, f, a, b);
      bad = 1'b1;
    end
  endtask

  // monitor: pops one expectation per cycle, after the outputs settle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = 1'b0;
        tests++;
        cmp(pend_word, e.word, "pend_word", e.tag, bad);
        cmp({31'd0, irq_out}, {31'd0, e.irq}, "irq_out", e.tag, bad);
        cmp({24'd0, ipi_prio}, {24'd0, e.ipi}, "ipi_prio", e.tag, bad);
        cmp({31'd0, offer_take}, {31'd0, e.take}, "offer_take", e.tag, bad);
        cmp({31'd0, offer_refuse}, {31'd0, e.refuse}, "offer_refuse", e.tag, bad);
        cmp({31'd0, rej_valid}, {31'd0, e.rej_v}, "rej_valid", e.tag, bad);
        if (e.rej_v) cmp({8'd0, rej_src}, {8'd0, e.rej_s}, "rej_src", e.tag, bad);
        cmp({31'd0, eoi_valid}, {31'd0, e.eoi_v}, "eoi_valid", e.tag, bad);
        if (e.eoi_v) cmp({8'd0, eoi_src}, {8'd0, e.eoi_s}, "eoi_src", e.tag, bad);
        cmp({31'd0, resend_req}, {31'd0, e.res}, "resend_req", e.tag, bad);
        cmp({31'd0, rsp_valid}, {31'd0, e.rsp_v}, "rsp_valid", e.tag, bad);
        if (e.rsp_v) cmp(rsp_word, e.rsp_w, "rsp_word", e.tag, bad);
        if (bad) fails++;
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    e = ex(32'h0000_0000, 0, 8'hFF, "R1 reset state");
    drive(0, ACC, 0, 0, 0, 0, e);

    e = ex(32'h0000_0000, 0, 8'hFF, "R2 offer vs cppr 0 refused");
    e.refuse = 1;
    drive(0, ACC, 0, 1, 24'h10, 8'd5, e);

    e = ex(32'hFF00_0000, 0, 8'hFF, "R7 cppr raised, nothing held, resend");
    e.res = 1;
    drive(1, CPPR, 32'hFF, 0, 0, 0, e);

    e = ex(32'hFF00_0010, 1, 8'hFF, "R4 offer taken");
    e.take = 1;
    drive(0, ACC, 0, 1, 24'h10, 8'd5, e);

    e = ex(32'hFF00_0010, 1, 8'hFF, "R3 equal pending priority refused");
    e.refuse = 1;
    drive(0, ACC, 0, 1, 24'h20, 8'd5, e);

    e = ex(32'hFF00_0021, 1, 8'hFF, "R4 preempt rejects held source");
    e.take = 1; e.rej_v = 1; e.rej_s = 24'h10;
    drive(0, ACC, 0, 1, 24'h21, 8'd3, e);

    e = ex(32'h0300_0000, 0, 8'hFF, "R5 accept");
    e.rsp_v = 1; e.rsp_w = 32'hFF00_0021;
    drive(1, ACC, 0, 0, 0, 0, e);

    e = ex(32'h0300_0000, 0, 8'hFF, "R2 offer equal to cppr refused");
    e.refuse = 1;
    drive(0, ACC, 0, 1, 24'h30, 8'd3, e);

    e = ex(32'h0300_0030, 1, 8'hFF, "R4 offer below cppr taken");
    e.take = 1;
    drive(0, ACC, 0, 1, 24'h30, 8'd2, e);

    e = ex(32'h0100_0000, 0, 8'hFF, "R6 favored cppr drops held");
    e.rej_v = 1; e.rej_s = 24'h30;
    drive(1, CPPR, 32'h01, 0, 0, 0, e);

    e = ex(32'h0700_0000, 0, 8'hFF, "R9 eoi with nothing held");
    e.eoi_v = 1; e.eoi_s = 24'h30; e.res = 1;
    drive(1, EOI, 32'h0700_0030, 0, 0, 0, e);

    e = ex(32'h0700_0000, 0, 8'h09, "R8 ipi above cppr not presented");
    drive(1, IPI, 32'h09, 0, 0, 0, e);

    e = ex(32'h0700_0002, 1, 8'h04, "R8 ipi presented");
    drive(1, IPI, 32'h04, 0, 0, 0, e);

    e = ex(32'h0700_0040, 1, 8'h04, "R10 offer displaces ipi without reject");
    e.take = 1;
    drive(0, ACC, 0, 1, 24'h40, 8'd2, e);

    e = ex(32'h0700_0040, 1, 8'h03, "R8 ipi skipped, held more favored");
    drive(1, IPI, 32'h03, 0, 0, 0, e);

    e = ex(32'h0700_0002, 1, 8'h01, "R8 ipi preempts source, reject");
    e.rej_v = 1; e.rej_s = 24'h40;
    drive(1, IPI, 32'h01, 0, 0, 0, e);

    e = ex(32'h0100_0000, 0, 8'h01, "R5 accept of ipi");
    e.rsp_v = 1; e.rsp_w = 32'h0700_0002;
    drive(1, ACC, 0, 0, 0, 0, e);

    e = ex(32'h0600_0002, 1, 8'h01, "R7 resend rechecks ipi");
    e.res = 1;
    drive(1, CPPR, 32'h06, 0, 0, 0, e);

    e = ex(32'h0100_0000, 0, 8'h01, "R11 accept then offer refused");
    e.rsp_v = 1; e.rsp_w = 32'h0600_0002; e.refuse = 1;
    drive(1, ACC, 0, 1, 24'h50, 8'd4, e);

    e = ex(32'h0100_0000, 0, 8'hFF, "R8 ipi cleared to lowest");
    drive(1, IPI, 32'hFF, 0, 0, 0, e);

    e = ex(32'h0800_0060, 1, 8'hFF, "R11 eoi then offer taken");
    e.eoi_v = 1; e.eoi_s = 24'h02; e.res = 1; e.take = 1;
    drive(1, EOI, 32'h0800_0002, 1, 24'h60, 8'd5, e);

    e = ex(32'h0500_0000, 0, 8'hFF, "R6 drop at equal pending priority");
    e.rej_v = 1; e.rej_s = 24'h60;
    drive(1, CPPR, 32'h05, 0, 0, 0, e);

    e = ex(32'h0200_0000, 0, 8'hFF, "R7 favored write with nothing held, no resend");
    drive(1, CPPR, 32'h02, 0, 0, 0, e);

    e = ex(32'hFF00_0000, 0, 8'hFF, "R7 cppr lowered again, resend");
    e.res = 1;
    drive(1, CPPR, 32'hFF, 0, 0, 0, e);

    e = ex(32'hFF00_0070, 1, 8'hFF, "R4 offer taken again");
    e.take = 1;
    drive(0, ACC, 0, 1, 24'h70, 8'd9, e);

    e = ex(32'h0A00_0070, 1, 8'hFF, "R9 eoi with held, no resend");
    e.eoi_v = 1; e.eoi_s = 24'h11;
    drive(1, EOI, 32'h0A00_0011, 0, 0, 0, e);

    e = ex(32'h0A00_0070, 1, 8'hFF, "R1 idle hold");
    drive(0, ACC, 0, 0, 0, 0, e);

    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule